// File: doc/BRIEF.md
# Auto-Reload Tick Timer

A 32-bit down-counter that runs from a 32.768 kHz clock and advances only on count ticks made by an internal prescaler. Software stores a preset value. The counter steps down by one on each tick. On the tick that finds it at zero, it takes the preset again and keeps running. A preset of N therefore gives one reload every N+1 ticks.

The prescaler has two rates. The slow rate gives one tick per 32768 clocks, which is 1 Hz. The fast rate gives close to 1 kHz by mixing 32-clock and 33-clock periods: 768 periods out of every 1000 are long, so any 1000 consecutive fast ticks span exactly 32768 clocks. Each reload drives a one-cycle pulse and sets a sticky interrupt flag. Software clears the flag by writing 1.

Top module: `reloadTickTimer`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `count`, `irqPulse` and `irqFlag` are all 0.
- R2: While `enable` is high, each tick lowers `count` by one. While `enable` is low, `count` holds and the prescaler is held at its start. The first tick after `enable` rises therefore comes one full period later.
- R3: A tick that finds `count` at 0 loads the stored preset instead of decrementing. `irqPulse` is 1 for exactly the cycle in which `count` first shows the reloaded value.
- R4: A cycle with `presetWr` high stores `presetWrData` as the preset and also loads it into `count` at the next clock edge. This happens whether or not `enable` is high, and it takes priority over a tick in the same cycle.
- R5: With `rateFast` = 0, ticks are spaced 32768 clocks apart.
- R6: With `rateFast` = 1, fast period k is counted from 0 since the prescaler last restarted. It lasts 33 clocks when floor((k+1)*768/1000) > floor(k*768/1000), and 32 clocks otherwise. Any 1000 consecutive fast ticks span 32768 clocks.
- R7: `irqFlag` becomes 1 on each reload and stays 1 until a cycle with `irqClear` = 1 clears it. A reload in the same cycle as a clear leaves the flag at 1.
- R8: A change of `rateFast` restarts the prescaler. No tick occurs in that cycle, and the fast period index returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the prescaler and the counter |
| rateFast | input | 1 | 1 selects the ~1 kHz tick, 0 selects the 1 Hz tick |
| presetWr | input | 1 | Write strobe for the preset |
| presetWrData | input | 32 | New preset value |
| irqClear | input | 1 | Write-1-to-clear for the interrupt flag |
| count | output | 32 | Current counter value |
| irqPulse | output | 1 | One-cycle pulse on each reload |
| irqFlag | output | 1 | Sticky reload interrupt flag |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a reload. The bench has to know one cycle ahead that the counter is at zero and that the prescaler is on the last clock of its period, and the fast period length changes from tick to tick. The bench keeps its own model of the prescaler phase and the long/short period index. It polls that model until the next edge is predicted to reload, and only then raises `irqClear`. The 1000-tick fast window and the 1 Hz spacing are measured by timing changes of `count`, and are compared against the model's period formula.

// File: rtl/tickTimerPkg.sv
package tickTimerPkg;
  typedef struct packed {
    logic load;    // take the new preset into both registers
    logic step;    // decrement the counter
    logic reload;  // counter at zero on a tick: copy the preset back
  } ctrlStrobes_t;
endpackage

// File: rtl/tickPrescaler.sv
module tickPrescaler #(
  parameter int SLOW_DIV  = 32768,
  parameter int FAST_BASE = 32,
  parameter int FAST_NUM  = 768,
  parameter int FAST_DEN  = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic rateFast,
  output logic tick
);
  localparam int DIV_W = $clog2(SLOW_DIV);
  localparam int ACC_W = $clog2(FAST_DEN) + 1;

  logic             rateQ;
  logic             rateChange;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] lastCnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] accNext;
  logic             longPeriod;

  assign rateChange = rateFast != rateQ;

  generate
    if (FAST_NUM == 0) begin : gNoStretch
      assign longPeriod = 1'b0;
      assign accSum     = acc;
      assign accNext    = acc;
    end else begin : gStretch
      // acc holds k*FAST_NUM mod FAST_DEN; the period is long when it wraps
      assign accSum     = acc + ACC_W'(FAST_NUM);
      assign longPeriod = accSum >= ACC_W'(FAST_DEN);
      assign accNext    = longPeriod ? accSum - ACC_W'(FAST_DEN) : accSum;
    end
  endgenerate

  assign lastCnt = rateFast ? DIV_W'(FAST_BASE - 1) + DIV_W'(longPeriod)
                            : DIV_W'(SLOW_DIV - 1);
  assign tick    = enable && !rateChange && (divCnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ  <= 1'b0;
      divCnt <= '0;
      acc    <= '0;
    end else begin
      rateQ <= rateFast;
      if (!enable || rateChange) begin
        divCnt <= '0;
        acc    <= '0;
      end else if (tick) begin
        divCnt <= '0;
        if (rateFast) acc <= accNext;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R2: the prescaler is idle the cycle after enable is low
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> divCnt == '0);
  // R8: a rate change restarts the period
  p_rate_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rateFast != $past(rateFast)) && $past(rstN) |-> !tick);
endmodule

// File: rtl/timerControl.sv
module timerControl
  import tickTimerPkg::*;
#(
  parameter int SLOW_DIV  = 32768,
  parameter int FAST_BASE = 32,
  parameter int FAST_NUM  = 768,
  parameter int FAST_DEN  = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         rateFast,
  input  logic         presetWr,
  input  logic         irqClear,
  input  logic         isZero,
  output ctrlStrobes_t strobes,
  output logic         irqPulse,
  output logic         irqFlag
);
  logic tick;

  tickPrescaler #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_BASE(FAST_BASE),
    .FAST_NUM (FAST_NUM),
    .FAST_DEN (FAST_DEN)
  ) uPrescaler (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .rateFast(rateFast),
    .tick    (tick)
  );

  always_comb begin
    strobes.load   = presetWr;
    strobes.step   = tick && !presetWr && !isZero;
    strobes.reload = tick && !presetWr && isZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      irqPulse <= strobes.reload;
      if (strobes.reload)  irqFlag <= 1'b1;
      else if (irqClear)   irqFlag <= 1'b0;
    end
  end

  // R3: the pulse lasts one cycle (periods are far longer than one clock)
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
  // R7: a pulse always comes with the flag set
  p_flag_with_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> irqFlag);
  // R7: a clear with no reload drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqClear && !strobes.reload |=> !irqFlag);
endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import tickTimerPkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [COUNT_W-1:0] presetWrData,
  output logic [COUNT_W-1:0] count,
  output logic               isZero
);
  logic [COUNT_W-1:0] presetQ;
  logic [COUNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presetQ <= '0;
      countQ  <= '0;
    end else if (strobes.load) begin
      presetQ <= presetWrData;
      countQ  <= presetWrData;
    end else if (strobes.reload) begin
      countQ <= presetQ;
    end else if (strobes.step) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign count  = countQ;
  assign isZero = countQ == '0;

  // R4: a write lands in the counter at the next edge
  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> count == $past(presetWrData));
  // R2: a step lowers the count by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> count == $past(count) - 1'b1);
  // R3: a reload restores the stored preset
  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> count == $past(presetQ));
endmodule

// File: rtl/reloadTickTimer.sv
module reloadTickTimer
  import tickTimerPkg::*;
#(
  parameter int COUNT_W   = 32,
  parameter int SLOW_DIV  = 32768,
  parameter int FAST_BASE = 32,
  parameter int FAST_NUM  = 768,
  parameter int FAST_DEN  = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               rateFast,
  input  logic               presetWr,
  input  logic [COUNT_W-1:0] presetWrData,
  input  logic               irqClear,
  output logic [COUNT_W-1:0] count,
  output logic               irqPulse,
  output logic               irqFlag
);
  ctrlStrobes_t strobes;
  logic         isZero;

  timerControl #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_BASE(FAST_BASE),
    .FAST_NUM (FAST_NUM),
    .FAST_DEN (FAST_DEN)
  ) uControl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .rateFast(rateFast),
    .presetWr(presetWr),
    .irqClear(irqClear),
    .isZero  (isZero),
    .strobes (strobes),
    .irqPulse(irqPulse),
    .irqFlag (irqFlag)
  );

  timerDatapath #(
    .COUNT_W(COUNT_W)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .presetWrData(presetWrData),
    .count       (count),
    .isZero      (isZero)
  );

  // R2: with enable low and no write the count does not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !presetWr |=> $stable(count));
endmodule

// File: tb/reloadTickTimer_test.sv
module reloadTickTimer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        rateFast = 1'b0;
  logic        presetWr = 1'b0;
  logic [31:0] presetWrData = '0;
  logic        irqClear = 1'b0;
  logic [31:0] count;
  logic        irqPulse;
  logic        irqFlag;

  reloadTickTimer uut (
    .clk(clk), .rstN(rstN), .enable(enable), .rateFast(rateFast),
    .presetWr(presetWr), .presetWrData(presetWrData), .irqClear(irqClear),
    .count(count), .irqPulse(irqPulse), .irqFlag(irqFlag)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] cnt;
    logic        pulse;
    logic        flag;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  string phase = "R1";

  // model state, updated from the requirements
  logic [31:0] mCount = '0, mPreset = '0;
  logic        mFlag = 0, mPulse = 0, mRateQ = 0;
  int          mDiv = 0, mK = 0;

  function automatic bit isLong(int k);
    return ((k + 1) * 768 / 1000) > (k * 768 / 1000);
  endfunction

  function automatic int periodOf(bit fast, int k);
    return fast ? (isLong(k) ? 33 : 32) : 32768;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // reference model: evaluates the edge just taken and pushes the expected outputs
  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rstN) begin
      mCount = '0; mPreset = '0; mFlag = 0; mPulse = 0; mRateQ = 0; mDiv = 0; mK = 0;
    end else begin
      bit chg, tk;
      chg = rateFast != mRateQ;
      mRateQ = rateFast;
      tk = enable && !chg && (mDiv == periodOf(rateFast, mK) - 1);
      if (!enable || chg) begin mDiv = 0; mK = 0; end
      else if (tk) begin mDiv = 0; if (rateFast) mK = (mK + 1) % 1000; end
      else mDiv++;
      mPulse = 0;
      if (presetWr) begin mPreset = presetWrData; mCount = presetWrData; end
      else if (tk) begin
        if (mCount == 0) begin mCount = mPreset; mPulse = 1; end
        else mCount = mCount - 1;
      end
      if (mPulse) mFlag = 1;
      else if (irqClear) mFlag = 0;
      expQ.push_back('{mCount, mPulse, mFlag, phase});
    end
  end

  // monitor: compares the design against the queued expectations
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(count == e.cnt, {e.tag, " count"}, count, e.cnt);
      check(irqPulse == e.pulse, {e.tag, " irqPulse"}, irqPulse, e.pulse);
      check(irqFlag == e.flag, {e.tag, " irqFlag"}, irqFlag, e.flag);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 195000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected <195000 cycles", cyc);
      finishRun();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writePreset(logic [31:0] v);
    @(negedge clk);
    presetWr = 1; presetWrData = v;
    @(negedge clk);
    presetWr = 0;
  endtask

  task automatic waitCount(logic [31:0] v, output int at);
    while (count != v) @(negedge clk);
    at = cyc;
  endtask

  initial begin
    int t0, t1;
    idle(3);
    // R1: reset state
    check(count == 0, "R1 count", count, 0);
    check(irqPulse == 0, "R1 irqPulse", irqPulse, 0);
    check(irqFlag == 0, "R1 irqFlag", irqFlag, 0);
    rstN = 1;
    @(negedge clk);
    check(count == 0 && !irqFlag, "R1 after release", count, 0);

    // R4: a write while stopped loads the counter at once
    phase = "R4";
    writePreset(5);
    check(count == 5, "R4 load while stopped", count, 5);
    phase = "R2";
    idle(50);
    check(count == 5, "R2 hold while disabled", count, 5);

    // R2 / R3 / R6: fast running with reloads
    phase = "R3";
    rateFast = 1; enable = 1;
    while (!irqPulse) @(negedge clk);
    check(count == 5, "R3 reload value with pulse", count, 5);
    check(irqFlag == 1, "R7 flag set on reload", irqFlag, 1);
    idle(400);

    // R7: clear, then clear colliding with a reload
    phase = "R7";
    irqClear = 1; @(negedge clk); irqClear = 0;
    check(irqFlag == 0, "R7 clear", irqFlag, 0);
    while (!(mCount == 0 && mDiv == periodOf(rateFast, mK) - 1)) @(negedge clk);
    irqClear = 1; @(negedge clk); irqClear = 0;
    check(irqFlag == 1, "R7 reload beats clear", irqFlag, 1);
    check(irqPulse == 1, "R3 pulse on collision reload", irqPulse, 1);

    // R4: a write while running
    phase = "R4";
    idle(45);
    writePreset(9);
    check(count == 9, "R4 load while running", count, 9);
    idle(300);

    // R8: rate change restarts the prescaler
    phase = "R8";
    rateFast = 0; idle(10); rateFast = 1;
    idle(500);

    // R2: disable mid-run
    phase = "R2";
    enable = 0;
    @(negedge clk);
    t0 = count;
    idle(100);
    check(count == t0, "R2 disabled hold", count, t0);

    // R6: 1000 fast ticks span 32768 clocks
    phase = "R6";
    writePreset(2000);
    enable = 1;
    waitCount(1999, t0);
    waitCount(999, t1);
    check(t1 - t0 == 32768, "R6 1000-tick window", t1 - t0, 32768);

    // R5: slow tick spacing
    phase = "R5";
    enable = 0; rateFast = 0;
    writePreset(3);
    enable = 1;
    waitCount(2, t0);
    check(t0 - cyc == 0, "R5 first tick seen", t0, cyc);
    waitCount(1, t1);
    check(t1 - t0 == 32768, "R5 1 Hz spacing", t1 - t0, 32768);
    idle(3);
    finishRun();
  end
endmodule